// File: doc/BRIEF.md
# Time-Compare Alarm and Periodic Pulse Generator

This block watches a 64-bit nanosecond time value supplied by an external time counter. It turns that time into timed pulses. Two alarm units each hold a 64-bit compare time. An alarm fires once when the time reaches or passes its compare time, and it then drives a pulse whose active level and length can be programmed. Up to four periodic channels (three by default) produce pulse trains at a fixed interval. A channel starts either as soon as it is enabled or on the next event of alarm 0. The pulse length of every channel is scaled by one shared even prescale factor.

Each alarm and each channel can hold its pulse start until the next tick strobe, so that output edges line up with the time base. Every alarm and channel event sets a sticky flag, and a mask turns the flags into one level request. A loopback selection chooses what reaches the timestamp trigger outputs: either the periodic pulses or the external trigger inputs.

Configuration arrives on a simple write port. It has no stream data path. Every write is accepted in the cycle it is presented, and there is no back-pressure.

Top module: `time_event_gen`

## Requirements
- R1: After reset, every alarm output and periodic output is low, all event flags and the request are low, both alarms are disarmed, all channels are disabled, and `ts_trig` equals `ext_trig`.
- R2: Writing an alarm's low word (address 0 for alarm 0, 2 for alarm 1) and then its high word (address 1 or 3) arms that alarm. The alarm fires in the first cycle in which `cur_time` is at or above the compare value. Its output is then active for W cycles, starting in the cycle after that edge, where W is its width field (register 4, bits 15:8 for alarm 0 and 23:16 for alarm 1; a value of 0 means 1). An alarm fires only once per arming.
- R3: Any write to an alarm's low word disarms it. A high-word write arms the alarm only when the stored low word is nonzero, so writing zero to the low word stops the alarm.
- R4: An alarm's polarity bit (register 4, bit 0 or bit 1) inverts its output, so the idle level equals the polarity bit.
- R5: When an alarm's sync bit (register 4, bit 2 or bit 3) is set, its pulse starts at the first edge at which `tick` is high, at or after the fire edge. Its flag is still set at the fire edge.
- R6: Event flags are sticky: bits 0 and 1 belong to the alarms and bit 2+k to channel k. Writing a one to a bit of address 12 clears that bit, and zero bits leave their flags as they are. The mask is written at address 13, and `evt_irq` is the OR of the flags that are enabled in the mask.
- R7: In the immediate mode (register 6, bit 0 clear), an enabled channel with period P (address 8+k) that was enabled while the time was T pulses when the time reaches T+P, T+2P, and so on.
- R8: A channel's pulse is active for w×S cycles. Here w is the channel's width field (register 5, bits 8k+7:8k+1; 0 means 1) and S is the prescale (register 6, bits 15:8). The LSB of the prescale is ignored, and a value below 2 counts as 2.
- R9: In start-on-alarm mode (register 6, bit 0 set), an enabled channel produces no pulse until alarm 0 fires at compare time C. It then pulses at C+P, C+2P, and so on.
- R10: The disable bit of channel k is register 5, bit 8k, and it is set at reset. A channel's period and width writes are ignored while the channel is enabled. Setting the disable bit stops the channel, and its output is low from the second edge on.
- R11: When the loopback bit (register 6, bit 1) is set, `ts_trig` carries the periodic outputs. When it is clear, `ts_trig` carries `ext_trig`.
- R12: A channel whose period is zero never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_time | input | 64 | Current time in nanoseconds |
| tick | input | 1 | Time base strobe used for sync alignment |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| ext_trig | input | NUM_PER | External trigger inputs |
| alarm_out | output | 2 | Alarm pulse outputs |
| per_out | output | NUM_PER | Periodic pulse outputs |
| ts_trig | output | NUM_PER | Trigger sources passed on for timestamping |
| evt_flags | output | 2+NUM_PER | Sticky event flags |
| evt_irq | output | 1 | OR of the flags enabled by the mask |

## Verification
The bound checker checks four properties on every cycle. Flags stay set until a one is written to them. A fired alarm stays disarmed until its high word is written again. An enabled channel's period register never changes, and a channel that has been disabled for a cycle, or whose period is zero, stays quiet. Exact pulse positions and lengths can only be shown by the bench's directed scenarios. These cover the sync delay against the tick strobe, the effect of prescale rounding, the start-on-alarm schedule and the loopback selection, each checked against time values chosen by the bench.

// File: rtl/tsg_pkg.sv
`timescale 1ns/1ps
package tsg_pkg;
  localparam int NUM_ALM = 2;
  localparam int ADDR_W  = 4;

  localparam logic [ADDR_W-1:0] A_ALM_CFG  = 4'd4;
  localparam logic [ADDR_W-1:0] A_PER_CTRL = 4'd5;
  localparam logic [ADDR_W-1:0] A_PER_MODE = 4'd6;
  localparam logic [ADDR_W-1:0] A_PERIOD0  = 4'd8;
  localparam logic [ADDR_W-1:0] A_EVT      = 4'd12;
  localparam logic [ADDR_W-1:0] A_EVT_MASK = 4'd13;

  typedef enum logic [1:0] {CH_IDLE, CH_WAIT, CH_RUN} ch_state_e;
endpackage

// File: rtl/tsg_alarm.sv
`timescale 1ns/1ps
module tsg_alarm #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*DW-1:0] cur_time,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [DW-1:0]   wr_data,
  output logic            fire,
  output logic [2*DW-1:0] cmp_time,
  output logic            armed
);
  logic [DW-1:0] lo_q, hi_q;

  assign cmp_time = {hi_q, lo_q};
  assign fire     = armed && (cur_time >= cmp_time);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      armed <= 1'b0;
    end else if (wr_lo) begin
      lo_q  <= wr_data;
      armed <= 1'b0;
    end else if (wr_hi) begin
      hi_q  <= wr_data;
      armed <= (lo_q != '0);
    end else if (fire) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/tsg_pulse.sv
`timescale 1ns/1ps
module tsg_pulse #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          fire,
  input  logic          sync,
  input  logic          tick,
  input  logic [CW-1:0] len,
  output logic          active
);
  logic [CW-1:0] cnt_q;
  logic          pend_q;
  logic          go;
  logic [CW-1:0] len_eff;

  assign go      = (fire || pend_q) && (!sync || tick);
  assign len_eff = (len == '0) ? CW'(1) : len;
  assign active  = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (clr) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (go)               cnt_q <= len_eff;
      else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
      if (go)               pend_q <= 1'b0;
      else if (fire)        pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tsg_channel.sv
`timescale 1ns/1ps
module tsg_channel
  import tsg_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*DW-1:0] cur_time,
  input  logic            enable,
  input  logic            start_on_alm,
  input  logic            alm_fire,
  input  logic [2*DW-1:0] alm_time,
  input  logic [DW-1:0]   period,
  output logic            fire
);
  localparam int TW = 2 * DW;

  ch_state_e     st_q;
  logic [TW-1:0] next_q;
  logic [TW-1:0] per_ext;

  assign per_ext = TW'(period);
  assign fire    = (st_q == CH_RUN) && (cur_time >= next_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CH_IDLE;
      next_q <= '0;
    end else if (!enable) begin
      st_q <= CH_IDLE;
    end else begin
      case (st_q)
        CH_IDLE: if (period != '0) begin
          if (start_on_alm) st_q <= CH_WAIT;
          else begin
            next_q <= cur_time + per_ext;
            st_q   <= CH_RUN;
          end
        end
        CH_WAIT: if (alm_fire) begin
          next_q <= alm_time + per_ext;
          st_q   <= CH_RUN;
        end
        CH_RUN: if (fire) next_q <= next_q + per_ext;
        default: st_q <= CH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/time_event_gen.sv
`timescale 1ns/1ps
module time_event_gen
  import tsg_pkg::*;
#(
  parameter int DW      = 32,
  parameter int NUM_PER = 3,
  parameter int AW_W    = 8,
  parameter int PW_W    = 7,
  parameter int PRE_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2*DW-1:0]            cur_time,
  input  logic                       tick,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DW-1:0]              wr_data,
  input  logic [NUM_PER-1:0]         ext_trig,
  output logic [NUM_ALM-1:0]         alarm_out,
  output logic [NUM_PER-1:0]         per_out,
  output logic [NUM_PER-1:0]         ts_trig,
  output logic [NUM_ALM+NUM_PER-1:0] evt_flags,
  output logic                       evt_irq
);
  localparam int TW      = 2 * DW;
  localparam int NUM_EVT = NUM_ALM + NUM_PER;
  localparam int PCW     = PW_W + PRE_W;

  logic [NUM_ALM-1:0]            alm_pol_q, alm_sync_q;
  logic [NUM_ALM-1:0][AW_W-1:0]  alm_w_q;
  logic [NUM_PER-1:0]            per_dis_q, per_sync_q;
  logic [NUM_PER-1:0][PW_W-1:0]  per_w_q;
  logic [NUM_PER-1:0][DW-1:0]    period_q;
  logic                          soa_q, loop_q;
  logic [PRE_W-1:0]              presc_q;
  logic [NUM_EVT-1:0]            flags_q, mask_q;

  logic [NUM_ALM-1:0]            alm_fire, alm_act, alm_armed;
  logic [NUM_ALM-1:0][TW-1:0]    alm_time;
  logic [NUM_PER-1:0]            ch_fire;
  logic [NUM_PER-1:0][PCW-1:0]   ch_len;
  logic [PRE_W-1:0]              presc_eff;
  logic [NUM_EVT-1:0]            evt_set, evt_clr;

  assign presc_eff = (presc_q < PRE_W'(2)) ? PRE_W'(2) : presc_q;
  assign evt_set   = {ch_fire, alm_fire};
  assign evt_clr   = (wr_en && wr_addr == A_EVT) ? wr_data[NUM_EVT-1:0] : '0;

  always_comb begin
    for (int k = 0; k < NUM_PER; k++) begin
      ch_len[k] = ((per_w_q[k] == '0) ? PCW'(1) : PCW'(per_w_q[k])) * PCW'(presc_eff);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_pol_q  <= '0;
      alm_sync_q <= '0;
      alm_w_q    <= '0;
      per_dis_q  <= '1;
      per_sync_q <= '0;
      per_w_q    <= '0;
      period_q   <= '0;
      soa_q      <= 1'b0;
      loop_q     <= 1'b0;
      presc_q    <= '0;
      flags_q    <= '0;
      mask_q     <= '0;
    end else begin
      if (wr_en && wr_addr == A_ALM_CFG) begin
        for (int a = 0; a < NUM_ALM; a++) begin
          alm_pol_q[a]  <= wr_data[a];
          alm_sync_q[a] <= wr_data[NUM_ALM+a];
          alm_w_q[a]    <= wr_data[8+8*a +: AW_W];
        end
      end
      if (wr_en && wr_addr == A_PER_CTRL) begin
        for (int k = 0; k < NUM_PER; k++) begin
          per_dis_q[k] <= wr_data[8*k];
          if (per_dis_q[k]) per_w_q[k] <= wr_data[8*k+1 +: PW_W];
        end
      end
      if (wr_en && wr_addr == A_PER_MODE) begin
        soa_q      <= wr_data[0];
        loop_q     <= wr_data[1];
        per_sync_q <= wr_data[2 +: NUM_PER];
        presc_q    <= wr_data[8 +: PRE_W] & ~PRE_W'(1);
      end
      for (int k = 0; k < NUM_PER; k++) begin
        if (wr_en && wr_addr == (A_PERIOD0 + ADDR_W'(k)) && per_dis_q[k]) period_q[k] <= wr_data;
      end
      if (wr_en && wr_addr == A_EVT_MASK) mask_q <= wr_data[NUM_EVT-1:0];
      flags_q <= (flags_q & ~evt_clr) | evt_set;
    end
  end

  for (genvar a = 0; a < NUM_ALM; a++) begin : g_alm
    tsg_alarm #(.DW(DW)) u_alarm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cur_time (cur_time),
      .wr_lo    (wr_en && wr_addr == ADDR_W'(2*a)),
      .wr_hi    (wr_en && wr_addr == ADDR_W'(2*a+1)),
      .wr_data  (wr_data),
      .fire     (alm_fire[a]),
      .cmp_time (alm_time[a]),
      .armed    (alm_armed[a])
    );
    tsg_pulse #(.CW(AW_W)) u_shape (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (1'b0),
      .fire   (alm_fire[a]),
      .sync   (alm_sync_q[a]),
      .tick   (tick),
      .len    (alm_w_q[a]),
      .active (alm_act[a])
    );
    assign alarm_out[a] = alm_act[a] ^ alm_pol_q[a];
  end

  for (genvar k = 0; k < NUM_PER; k++) begin : g_ch
    tsg_channel #(.DW(DW)) u_chan (
      .clk          (clk),
      .rst_n        (rst_n),
      .cur_time     (cur_time),
      .enable       (!per_dis_q[k]),
      .start_on_alm (soa_q),
      .alm_fire     (alm_fire[0]),
      .alm_time     (alm_time[0]),
      .period       (period_q[k]),
      .fire         (ch_fire[k])
    );
    tsg_pulse #(.CW(PCW)) u_shape (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (per_dis_q[k]),
      .fire   (ch_fire[k]),
      .sync   (per_sync_q[k]),
      .tick   (tick),
      .len    (ch_len[k]),
      .active (per_out[k])
    );
  end

  assign ts_trig   = loop_q ? per_out : ext_trig;
  assign evt_flags = flags_q;
  assign evt_irq   = |(flags_q & mask_q);
endmodule

// File: rtl/time_event_gen_chk.sv
`timescale 1ns/1ps
module time_event_gen_chk
  import tsg_pkg::*;
#(
  parameter int DW      = 32,
  parameter int NUM_PER = 3
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           wr_en,
  input logic [ADDR_W-1:0]              wr_addr,
  input logic [NUM_ALM+NUM_PER-1:0]     clr_bits,
  input logic [NUM_ALM+NUM_PER-1:0]     evt_flags,
  input logic [NUM_ALM-1:0]             alm_armed,
  input logic [NUM_PER-1:0]             per_dis,
  input logic [NUM_PER-1:0][DW-1:0]     period,
  input logic [NUM_PER-1:0]             per_out
);
  for (genvar i = 0; i < NUM_ALM + NUM_PER; i++) begin : g_flag
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_flags[i] && !(wr_en && wr_addr == A_EVT && clr_bits[i])) |=> evt_flags[i]); // R6
  end

  for (genvar a = 0; a < NUM_ALM; a++) begin : g_alm
    AST_ALM_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (!alm_armed[a] && !(wr_en && wr_addr == ADDR_W'(2*a+1))) |=> !alm_armed[a]); // R2
  end

  for (genvar k = 0; k < NUM_PER; k++) begin : g_ch
    AST_PERIOD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(per_dis[k]) |-> $stable(period[k])); // R10
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (per_dis[k] && $past(per_dis[k])) |-> !per_out[k]); // R10
    AST_ZERO_PERIOD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (period[k] == '0) |-> !per_out[k]); // R12
  end
endmodule

bind time_event_gen time_event_gen_chk #(.DW(DW), .NUM_PER(NUM_PER)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .clr_bits  (wr_data[NUM_ALM+NUM_PER-1:0]),
  .evt_flags (evt_flags),
  .alm_armed (alm_armed),
  .per_dis   (per_dis_q),
  .period    (period_q),
  .per_out   (per_out)
);

// File: tb/test_time_event_gen.sv
`timescale 1ns/1ps
module test_time_event_gen;
  import tsg_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cur_time = '0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  ext_trig = 3'b101;
  logic [1:0]  alarm_out;
  logic [2:0]  per_out, ts_trig;
  logic [4:0]  evt_flags;
  logic        evt_irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  time_event_gen i_time_event_gen (
    .clk(clk), .rst_n(rst_n), .cur_time(cur_time), .tick(tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ext_trig(ext_trig),
    .alarm_out(alarm_out), .per_out(per_out), .ts_trig(ts_trig),
    .evt_flags(evt_flags), .evt_irq(evt_irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [63:0] t, input logic tk);
    @(negedge clk);
    cur_time = t;
    tick     = tk;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    tick    = 1'b0;
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 alarm_out", 64'(alarm_out), 64'd0);
    check("R1 per_out", 64'(per_out), 64'd0);
    check("R1 flags", 64'(evt_flags), 64'd0);
    check("R1 irq", 64'(evt_irq), 64'd0);
    check("R1 ts_trig", 64'(ts_trig), 64'(ext_trig));
  endtask

  task automatic t_alarm_basic;
    wr(4'd4, 32'h0000_0300);
    step(900, 1);
    wr(4'd0, 32'd1000);
    wr(4'd1, 32'd0);
    step(992, 1);  check("R2 before compare", 64'(alarm_out[0]), 64'd0);
    step(1000, 1); check("R2 fires", 64'(alarm_out[0]), 64'd1);
    check("R6 flag set", 64'(evt_flags), 64'd1);
    check("R6 masked irq", 64'(evt_irq), 64'd0);
    step(1008, 1); check("R2 width c2", 64'(alarm_out[0]), 64'd1);
    step(1016, 1); check("R2 width c3", 64'(alarm_out[0]), 64'd1);
    step(1024, 1); check("R2 width end", 64'(alarm_out[0]), 64'd0);
    step(1100, 1); check("R2 fires once", 64'(alarm_out[0]), 64'd0);
    wr(A_EVT_MASK, 32'h1); check("R6 irq enabled", 64'(evt_irq), 64'd1);
    wr(A_EVT, 32'h1);
    check("R6 w1c", 64'(evt_flags), 64'd0);
    check("R6 irq cleared", 64'(evt_irq), 64'd0);
  endtask

  task automatic t_alarm_stop;
    wr(4'd0, 32'd2000);
    wr(4'd1, 32'd0);
    wr(4'd0, 32'd0);
    step(2000, 1);
    step(2008, 1);
    check("R3 stopped out", 64'(alarm_out[0]), 64'd0);
    check("R3 stopped flag", 64'(evt_flags[0]), 64'd0);
    wr(4'd1, 32'd0);
    step(2100, 1);
    check("R3 zero low not armed", 64'(evt_flags[0]), 64'd0);
  endtask

  task automatic t_polarity;
    wr(4'd4, 32'h0000_0101);
    step(2200, 1); check("R4 idle high", 64'(alarm_out[0]), 64'd1);
    wr(4'd0, 32'd2300);
    wr(4'd1, 32'd0);
    step(2300, 1); check("R4 active low", 64'(alarm_out[0]), 64'd0);
    step(2308, 1); check("R4 back idle", 64'(alarm_out[0]), 64'd1);
    wr(A_EVT, 32'h1F);
  endtask

  task automatic t_sync_flags;
    wr(4'd4, 32'h0002_0008);
    wr(4'd2, 32'd3000);
    wr(4'd3, 32'd0);
    step(3000, 0);
    check("R5 waits for tick", 64'(alarm_out[1]), 64'd0);
    check("R5 flag at fire", 64'(evt_flags), 64'd2);
    step(3008, 0); check("R5 still waiting", 64'(alarm_out[1]), 64'd0);
    step(3016, 1); check("R5 starts on tick", 64'(alarm_out[1]), 64'd1);
    step(3024, 0); check("R5 width c2", 64'(alarm_out[1]), 64'd1);
    step(3032, 0); check("R5 width end", 64'(alarm_out[1]), 64'd0);
    wr(4'd0, 32'd3100);
    wr(4'd1, 32'd0);
    step(3100, 1); check("R6 both flags", 64'(evt_flags), 64'd3);
    wr(A_EVT, 32'h1); check("R6 partial clear", 64'(evt_flags), 64'd2);
    wr(A_EVT, 32'h2); check("R6 all clear", 64'(evt_flags), 64'd0);
  endtask

  task automatic t_periodic;
    step(5000, 1);
    wr(A_PER_MODE, 32'h0000_0500);
    wr(A_PER_CTRL, 32'h0001_0105);
    wr(4'd8, 32'd100);
    wr(A_PER_CTRL, 32'h0001_0104);
    step(5000, 1);
    step(5096, 1); check("R7 before period", 64'(per_out[0]), 64'd0);
    step(5100, 1); check("R7 first pulse", 64'(per_out[0]), 64'd1);
    check("R6 channel flag", 64'(evt_flags[2]), 64'd1);
    for (int i = 1; i < 8; i++) begin
      step(64'(5100 + 8*i), 1); check("R8 width held", 64'(per_out[0]), 64'd1);
    end
    step(5164, 1); check("R8 width w*S", 64'(per_out[0]), 64'd0);
    wr(4'd8, 32'd40);
    wr(A_PER_CTRL, 32'h0001_0108);
    step(5196, 1); check("R7 gap", 64'(per_out[0]), 64'd0);
    step(5200, 1); check("R7 second pulse", 64'(per_out[0]), 64'd1);
    for (int i = 1; i < 8; i++) begin
      step(64'(5200 + 8*i), 1); check("R10 width kept", 64'(per_out[0]), 64'd1);
    end
    step(5264, 1); check("R10 width write ignored", 64'(per_out[0]), 64'd0);
    step(5296, 1); check("R10 period write ignored", 64'(per_out[0]), 64'd0);
    step(5300, 1); check("R10 third pulse", 64'(per_out[0]), 64'd1);
    wr(A_PER_CTRL, 32'h0001_0101);
    step(5304, 1);
    step(5312, 1); check("R10 disable stops", 64'(per_out[0]), 64'd0);
    step(5400, 1); check("R10 stays stopped", 64'(per_out[0]), 64'd0);
    wr(A_EVT, 32'h1F);
  endtask

  task automatic t_zero_period;
    wr(A_PER_CTRL, 32'h0001_0001);
    step(5500, 1);
    step(5600, 1); check("R12 no pulse", 64'(per_out[1]), 64'd0);
    step(6000, 1); check("R12 no pulse later", 64'(per_out[1]), 64'd0);
    check("R12 no flag", 64'(evt_flags[3]), 64'd0);
    wr(A_PER_CTRL, 32'h0001_0101);
  endtask

  task automatic t_start_on_alarm;
    wr(4'd4, 32'h0);
    step(8000, 1);
    wr(A_PER_MODE, 32'h0000_0401);
    wr(A_PER_CTRL, 32'h0003_0101);
    wr(4'd10, 32'd200);
    wr(A_PER_CTRL, 32'h0002_0101);
    check("R11 external path", 64'(ts_trig), 64'b101);
    step(8000, 1);
    wr(4'd0, 32'd8500);
    wr(4'd1, 32'd0);
    step(8200, 1); check("R9 waits for alarm", 64'(per_out[2]), 64'd0);
    step(8300, 1); check("R9 still waiting", 64'(per_out[2]), 64'd0);
    step(8500, 1); check("R9 no pulse at alarm", 64'(per_out[2]), 64'd0);
    step(8696, 1); check("R9 before C+P", 64'(per_out[2]), 64'd0);
    step(8700, 1); check("R9 pulse at C+P", 64'(per_out[2]), 64'd1);
    step(8708, 1);
    step(8716, 1);
    step(8724, 1); check("R8 width 1x4 c4", 64'(per_out[2]), 64'd1);
    step(8732, 1); check("R8 width 1x4 end", 64'(per_out[2]), 64'd0);
    step(8896, 1);
    wr(A_PER_MODE, 32'h0000_0403);
    check("R11 loopback idle", 64'(ts_trig), 64'b000);
    step(8900, 1);
    check("R9 pulse at C+2P", 64'(per_out[2]), 64'd1);
    check("R11 loopback pulse", 64'(ts_trig), 64'b100);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_alarm_basic();
    t_alarm_stop();
    t_polarity();
    t_sync_flags();
    t_periodic();
    t_zero_period();
    t_start_on_alarm();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule